// File: doc/BRIEF.md
# Byte-Grouped GPIO Port with Interrupts

This block is a general-purpose I/O port with 32 pins by default. Software sets a direction per pin. It drives output pins through a value register, which also has set and clear aliases. A polarity bit per pin can invert the pin's input. The port watches the polarity-adjusted inputs for rising transitions. Each rising transition latches a cause bit. A mask, which can be written through either of two addresses, routes these events onto one interrupt line for each byte of pins.

A single mode bit chooses how the group interrupts clear. In edge mode a group line stays high until software rewrites the cause bits of that group to all zeros. In level mode the line drops by itself once every input pin of the group is low again. External inputs pass through a two-flop synchroniser before any comparison is made.

All registers are reached through a plain 32-bit register port. A write is a single-cycle strobe with an address. Read data is combinational from the address, with no read strobe, so the port has no back-pressure. The pins and interrupt lines are plain level signals.

Top module: `gpio_grp_port`

Register word addresses:

| Address | Register |
|---------|----------|
| 0x0 | DIR |
| 0x1 | VAL |
| 0x2 | SET |
| 0x3 | CLR |
| 0x4 | POL |
| 0x5 | CAUSE |
| 0x6 | MASK (first address) |
| 0x7 | MASK (alias) |
| 0x8 | CTRL |

Unmapped addresses read 0.

## Requirements
- R1: DIR (address 0x0) drives `pin_oe` directly. A 1 in a bit makes that pin an output. `pin_oe` changes only in the cycle after a DIR write.
- R2: A write to VAL (address 0x1) updates only the pins whose DIR bit is 1. `pin_out` equals VAL AND DIR. For pins with DIR=0, VAL reads back the synchronised, polarity-adjusted input. That input takes effect on the third clock edge after `pin_in` changes.
- R3: A write to SET (0x2) ORs (data AND DIR) into VAL. A write to CLR (0x3) clears (data AND DIR) from VAL. Reading SET or CLR returns 0.
- R4: When a pin's bit in POL (0x4) is 1, its input is inverted before it is stored in VAL and before it is compared.
- R5: A 0-to-1 change of a polarity-adjusted input pin sets its bit in CAUSE (0x5). The bit stays set until software writes CAUSE, and a write replaces CAUSE with the written data.
- R6: A rising input on pin i whose mask bit is 1 raises `grp_irq[i/8]`. A rising input on an unmasked pin leaves the interrupt lines unchanged.
- R7: CTRL (0x8) bit 10 selects level mode when 1. CTRL reads back as 0x11FF0000 OR (mode << 10).
- R8: In level mode, a group line drops once all input pins of its group read 0 in VAL. In this mode a CAUSE write does not drop the line.
- R9: In edge mode, a CAUSE write that changes a group's cause bits and leaves that group all zero drops that group's line. A write that leaves the group's bits unchanged keeps the line.
- R10: Addresses 0x6 and 0x7 both read and write the same single mask register.
- R11: After reset, DIR, VAL, POL, CAUSE, MASK and the mode bit are 0, all `grp_irq` lines are low, and `pin_out` and `pin_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | N_PINS | Asynchronous pin inputs |
| pin_out | output | N_PINS | Pin output values (VAL AND DIR) |
| pin_oe | output | N_PINS | Pin output enables (DIR) |
| grp_irq | output | N_PINS/8 | One interrupt line per byte of pins |

## Verification
The assertions check the following on every cycle:
- `pin_oe` holds unless DIR was just written.
- A VAL, SET or CLR write reshapes `pin_out` only within the enabled outputs.
- SET and CLR read as zero.
- The fixed upper and lower fields of CTRL read correctly.

The bench scenarios cover the behaviours that depend on sequences of events:
- rising-edge capture through the synchroniser and the polarity inversion;
- the mask alias;
- whether a CAUSE write that leaves a group unchanged, or one that zeroes it, drops the line;
- level-mode release when the last high pin of a group falls.

A randomised phase runs edge mode against a bench model.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  typedef enum logic [3:0] {
    RA_DIR    = 4'h0,
    RA_VAL    = 4'h1,
    RA_SET    = 4'h2,
    RA_CLR    = 4'h3,
    RA_POL    = 4'h4,
    RA_CAUSE  = 4'h5,
    RA_MASK_A = 4'h6,
    RA_MASK_B = 4'h7,
    RA_CTRL   = 4'h8
  } reg_addr_e;

  localparam int          REG_W      = 32;
  localparam int          MODE_BIT   = 10;
  localparam logic [31:0] CTRL_FIXED = 32'h11FF_0000;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_val,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic         wr_pol,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] in_sync,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] value_q,
  output logic [N-1:0] rise
);
  logic [N-1:0] adj;
  logic [N-1:0] out_nxt;
  logic [N-1:0] value_d;

  // polarity-adjusted input, compared against the stored value
  assign adj  = in_sync ^ pol_q;
  assign rise = ~dir_q & adj & ~value_q;

  always_comb begin
    out_nxt = value_q;
    if (wr_val)      out_nxt = wdata;
    else if (wr_set) out_nxt = value_q | wdata;
    else if (wr_clr) out_nxt = value_q & ~wdata;
  end

  // outputs take written data, inputs follow the pins
  assign value_d = (out_nxt & dir_q) | (adj & ~dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pol_q   <= '0;
      value_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_pol) pol_q <= wdata;
      value_q <= value_d;
    end
  end
endmodule

// File: rtl/gpio_irq_grp.sv
module gpio_irq_grp #(
  parameter  int N     = 32,
  parameter  int GRP_W = 8,
  localparam int N_GRP = N / GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cause,
  input  logic             wr_mask,
  input  logic             wr_mode,
  input  logic [N-1:0]     wdata,
  input  logic             mode_in,
  input  logic [N-1:0]     rise,
  input  logic [N-1:0]     in_lvl,
  output logic [N-1:0]     cause_q,
  output logic [N-1:0]     mask_q,
  output logic             mode_q,
  output logic [N_GRP-1:0] grp_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      cause_q <= (wr_cause ? wdata : cause_q) | rise;
      if (wr_mask) mask_q <= wdata;
      if (wr_mode) mode_q <= mode_in;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic hit;
    logic edge_clr;
    logic lvl_clr;

    assign hit      = |(rise[g*GRP_W +: GRP_W] & mask_q[g*GRP_W +: GRP_W]);
    assign edge_clr = ~mode_q & wr_cause
                    & (cause_q[g*GRP_W +: GRP_W] != wdata[g*GRP_W +: GRP_W])
                    & ~|wdata[g*GRP_W +: GRP_W];
    assign lvl_clr  = mode_q & ~|in_lvl[g*GRP_W +: GRP_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    grp_irq[g] <= 1'b0;
      else if (hit)                  grp_irq[g] <= 1'b1;
      else if (edge_clr || lvl_clr)  grp_irq[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_grp_port.sv
module gpio_grp_port
  import gpio_grp_pkg::*;
#(
  parameter  int N_PINS = 32,
  parameter  int GRP_W  = 8,
  localparam int N_GRP  = N_PINS / GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_GRP-1:0]  grp_irq
);
  logic [N_PINS-1:0] in_sync, dir_q, pol_q, value_q, rise;
  logic [N_PINS-1:0] cause_q, mask_q, wd;
  logic              mode_q;
  logic              wr_dir, wr_val, wr_set, wr_clr, wr_pol;
  logic              wr_cause, wr_mask, wr_ctrl;

  assign wd       = reg_wdata[N_PINS-1:0];
  assign wr_dir   = reg_wr && (reg_addr == RA_DIR);
  assign wr_val   = reg_wr && (reg_addr == RA_VAL);
  assign wr_set   = reg_wr && (reg_addr == RA_SET);
  assign wr_clr   = reg_wr && (reg_addr == RA_CLR);
  assign wr_pol   = reg_wr && (reg_addr == RA_POL);
  assign wr_cause = reg_wr && (reg_addr == RA_CAUSE);
  assign wr_mask  = reg_wr && ((reg_addr == RA_MASK_A) || (reg_addr == RA_MASK_B));
  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  gpio_pin_bank #(.N(N_PINS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(wr_dir), .wr_val(wr_val), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_pol(wr_pol), .wdata(wd), .in_sync(in_sync),
    .dir_q(dir_q), .pol_q(pol_q), .value_q(value_q), .rise(rise)
  );

  gpio_irq_grp #(.N(N_PINS), .GRP_W(GRP_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_cause(wr_cause), .wr_mask(wr_mask), .wr_mode(wr_ctrl),
    .wdata(wd), .mode_in(reg_wdata[MODE_BIT]),
    .rise(rise), .in_lvl(value_q & ~dir_q),
    .cause_q(cause_q), .mask_q(mask_q), .mode_q(mode_q), .grp_irq(grp_irq)
  );

  assign pin_oe  = dir_q;
  assign pin_out = value_q & dir_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DIR:               reg_rdata = REG_W'(dir_q);
      RA_VAL:               reg_rdata = REG_W'(value_q);
      RA_POL:               reg_rdata = REG_W'(pol_q);
      RA_CAUSE:             reg_rdata = REG_W'(cause_q);
      RA_MASK_A, RA_MASK_B: reg_rdata = REG_W'(mask_q);
      RA_CTRL:              reg_rdata = CTRL_FIXED | (REG_W'(mode_q) << MODE_BIT);
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_grp_port_chk.sv
module gpio_grp_port_chk
  import gpio_grp_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe
);
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == RA_DIR) |=> $stable(pin_oe)); // R1

  AST_VAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_VAL) |=>
      pin_out == ($past(reg_wdata[N_PINS-1:0]) & pin_oe)); // R2

  AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_SET) |=>
      pin_out == ($past(pin_out) | ($past(reg_wdata[N_PINS-1:0]) & $past(pin_oe)))); // R3

  AST_CLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_CLR) |=>
      pin_out == ($past(pin_out) & ~($past(reg_wdata[N_PINS-1:0]) & $past(pin_oe)))); // R3

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_SET || reg_addr == RA_CLR) |-> reg_rdata == 32'h0); // R3

  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_CTRL) |->
      (reg_rdata[31:16] == 16'h11FF && reg_rdata[9:0] == 10'h0
       && reg_rdata[15:11] == 5'h0)); // R7
endmodule

bind gpio_grp_port gpio_grp_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_grp_port.sv
`timescale 1ns/1ps
module test_gpio_grp_port;
  localparam logic [3:0] A_DIR = 4'h0, A_VAL = 4'h1, A_SET = 4'h2, A_CLR = 4'h3,
                         A_POL = 4'h4, A_CAUSE = 4'h5, A_MSKA = 4'h6,
                         A_MSKB = 4'h7, A_CTRL = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [3:0]  grp_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_dir, m_pol, m_vreg, m_cause, m_mask;
  logic [3:0]  m_grp;

  always #2 clk = ~clk;

  gpio_grp_port i_gpio_grp_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_dir = '0; m_pol = '0; m_vreg = '0; m_cause = '0; m_mask = '0; m_grp = '0;
  endtask

  // edge-mode model of one settling step after a stimulus
  function automatic void model_settle();
    logic [31:0] adj, rise;
    adj  = pin_in ^ m_pol;
    rise = ~m_dir & adj & ~m_vreg;
    m_vreg  = (m_vreg & m_dir) | (adj & ~m_dir);
    m_cause = m_cause | rise;
    for (int g = 0; g < 4; g++)
      if (|(rise[g*8 +: 8] & m_mask[g*8 +: 8])) m_grp[g] = 1'b1;
  endfunction

  function automatic void model_cause_wr(input logic [31:0] w);
    for (int g = 0; g < 4; g++)
      if (m_cause[g*8 +: 8] != w[g*8 +: 8] && w[g*8 +: 8] == 8'h0) m_grp[g] = 1'b0;
    m_cause = w;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    do_reset();

    // R11: reset state
    check(pin_oe, 32'h0, "R11 pin_oe");
    check(pin_out, 32'h0, "R11 pin_out");
    check({28'h0, grp_irq}, 32'h0, "R11 grp_irq");
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      check(d, 32'h0, "R11 register reset");
    end
    rd(A_CTRL, d); check(d, 32'h11FF0000, "R7 ctrl reset readback");

    // R1, R2, R3: direction gating of value writes
    wr(A_DIR, 32'h0000FFFF);
    check(pin_oe, 32'h0000FFFF, "R1 oe follows DIR");
    wr(A_VAL, 32'hFFFFFFFF);
    check(pin_out, 32'h0000FFFF, "R2 value write gated");
    rd(A_VAL, d); check(d, 32'h0000FFFF, "R2 value readback");
    wr(A_SET, 32'h00FF0000);
    check(pin_out, 32'h0000FFFF, "R3 set on inputs ignored");
    rd(A_VAL, d); check(d, 32'h0000FFFF, "R3 value after set");
    wr(A_CLR, 32'h0000000F);
    check(pin_out, 32'h0000FFF0, "R3 clear");
    rd(A_SET, d); check(d, 32'h0, "R3 set reads 0");
    rd(A_CLR, d); check(d, 32'h0, "R3 clr reads 0");

    // R4, R5, R6: polarity, cause capture, unmasked event
    wr(A_DIR, 32'h0);
    wr(A_POL, 32'h000000F0);
    settle();
    rd(A_VAL, d); check(d, 32'h000000F0, "R4 inverted inputs");
    rd(A_CAUSE, d); check(d, 32'h000000F0, "R5 cause from polarity rise");
    check({28'h0, grp_irq}, 32'h0, "R6 unmasked no irq");
    pin_in = 32'h000000F0;
    settle();
    rd(A_VAL, d); check(d, 32'h0, "R4 inverted high reads 0");
    rd(A_CAUSE, d); check(d, 32'h000000F0, "R5 cause sticky");
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, d); check(d, 32'h0, "R5 cause write replaces");

    // R10: mask alias; R6: masked rise
    wr(A_MSKB, 32'h00000100);
    rd(A_MSKA, d); check(d, 32'h00000100, "R10 mask alias");
    pin_in = 32'h000001F0;
    settle();
    rd(A_CAUSE, d); check(d, 32'h00000100, "R5 cause pin8");
    check({28'h0, grp_irq}, 32'h2, "R6 group1 irq");

    // R9: edge-mode clearing
    wr(A_CAUSE, 32'h00000101);
    settle();
    check({28'h0, grp_irq}, 32'h2, "R9 unchanged group keeps irq");
    wr(A_CAUSE, 32'h00000001);
    settle();
    check({28'h0, grp_irq}, 32'h0, "R9 zeroed group clears irq");

    // R7, R8: level mode
    wr(A_CTRL, 32'h00000400);
    rd(A_CTRL, d); check(d, 32'h11FF0400, "R7 ctrl level readback");
    wr(A_MSKA, 32'h00000300);
    rd(A_MSKB, d); check(d, 32'h00000300, "R10 alias other way");
    pin_in = 32'h000003F0;
    settle();
    check({28'h0, grp_irq}, 32'h2, "R8 level rise asserts");
    pin_in = 32'h000001F0;
    settle();
    check({28'h0, grp_irq}, 32'h2, "R8 one pin still high");
    wr(A_CAUSE, 32'h0);
    settle();
    check({28'h0, grp_irq}, 32'h2, "R8 cause write ignored in level mode");
    pin_in = 32'h000000F0;
    settle();
    check({28'h0, grp_irq}, 32'h0, "R8 all low clears");

    // random phase in edge mode against the model
    do_reset();
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] w;
      op = int'($urandom_range(0, 7));
      w  = $urandom;
      case (op)
        0: begin wr(A_DIR, w); m_dir = w; end
        1: begin wr(A_VAL, w); m_vreg = (m_vreg & ~m_dir) | (w & m_dir); end
        2: begin wr(A_SET, w); m_vreg = m_vreg | (w & m_dir); end
        3: begin wr(A_CLR, w); m_vreg = m_vreg & ~(w & m_dir); end
        4: begin wr(A_POL, w); m_pol = w; end
        5: begin w = w & $urandom; wr(A_CAUSE, w); model_cause_wr(w); end
        6: begin wr((w[0] ? A_MSKA : A_MSKB), w); m_mask = w; end
        default: begin @(negedge clk); pin_in = w; end
      endcase
      settle();
      model_settle();
      check(pin_oe, m_dir, "R1 random oe");
      check(pin_out, m_vreg & m_dir, "R2 random pin_out");
      rd(A_VAL, d); check(d, m_vreg, "R4 random value");
      rd(A_CAUSE, d); check(d, m_cause, "R5 random cause");
      check({28'h0, grp_irq}, {28'h0, m_grp}, "R6 R9 random irq");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule